// File: doc/BRIEF.md
# MDIO Management Bus Master

This block is a synchronous master for the two-wire serial management bus that reaches the registers of an Ethernet PHY. It makes the management clock (MDC) from the system clock with a parameterised divider. It drives the bidirectional data line through separate output, output-enable and input signals, so a pad cell outside the block forms the tristate. A host starts one register read or one register write through a valid/ready request. The request carries a direction bit, a 5-bit PHY address, a 5-bit register address and 16 bits of write data. The block answers with a one-clock done pulse and, for reads, 16 bits of captured data.

Every frame opens with a 40-bit all-ones preamble, which is longer than the common 32 bits. Every frame closes with one extra MDC pulse during which the line is released. Outgoing bits change only at the start of the low half of MDC, so the PHY always samples stable data on the rising edge. While the bus is idle, MDC rests low and the line is not driven.

Top module: `mdio_master`

## Requirements
- R1: During reset, and whenever no frame is in progress, `mdc` is 0 and `mdio_oe` is 0. After reset `req_ready` is 1. A reset applied in the middle of a frame stops it and returns the block to idle.
- R2: Within a frame, every low half and every high half of `mdc` lasts exactly HALF_DIV system clocks. `mdio_oe` and `mdio_o` never change while `mdc` is high.
- R3: MDC pulses 0 to 39 of every frame carry a driven 1 (`mdio_oe`=1, `mdio_o`=1).
- R4: Pulses 40 and 41 carry a driven 0 and then a driven 1. Pulses 42 and 43 carry the opcode: 1 then 0 for a read, 0 then 1 for a write.
- R5: Pulses 44 to 48 carry the PHY address and pulses 49 to 53 carry the register address, each most significant bit first and driven.
- R6: A write drives 1 then 0 on pulses 54 and 55, then the 16 data bits most significant bit first on pulses 56 to 71. Pulse 72 has the line released. A write frame has 73 pulses in total.
- R7: A read releases the line from pulse 54 to the end of the frame, 72 pulses in total. The bit on `mdio_i` at the falling MDC edge that ends pulse k (k = 55 to 70) becomes read-data bit 70−k.
- R8: A request is taken only on a clock where `req_valid` and `req_ready` are both 1. `req_ready` is 0 for the whole frame, and request fields presented during a frame are ignored. `rsp_done` is a one-clock pulse in the first clock on which `req_ready` is 1 again. `rsp_rdata` holds its value until the next request is taken.
- R9: A request held valid through the clock in which `rsp_done` pulses is accepted on the next clock edge, with no idle clock in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Block idle, ready to take a request |
| req_read | input | 1 | 1 = register read, 0 = register write |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register address |
| req_wdata | input | 16 | Data for a write |
| rsp_done | output | 1 | One-clock pulse at the end of a frame |
| rsp_rdata | output | 16 | Data from the last read |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input value |

## Verification
Two things can happen in the same clock: the end of one frame, when `rsp_done` pulses and `req_ready` returns, and the acceptance of the next request. The bench provokes this by keeping `req_valid` high through an entire read frame, with fields changed after the first acceptance. It then checks three things. The first frame's bits on the line match the first request's fields. `rsp_done` and `req_ready` are high together. The second frame starts on the next edge and carries the second request's fields, with correct read data for both frames.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int ADDR_W    = 5;
    localparam int DATA_W    = 16;
    localparam int PRE_BITS  = 40;
    localparam int AOFF_W    = $clog2(ADDR_W);
    localparam int DOFF_W    = $clog2(DATA_W);

    // slot positions, one slot per MDC pulse
    localparam int ST_SLOT   = PRE_BITS;
    localparam int OP_SLOT   = ST_SLOT + 2;
    localparam int PA_SLOT   = OP_SLOT + 2;
    localparam int RA_SLOT   = PA_SLOT + ADDR_W;
    localparam int TA_SLOT   = RA_SLOT + ADDR_W;
    localparam int WD_SLOT   = TA_SLOT + 2;
    localparam int RD_SLOT   = TA_SLOT + 1;
    localparam int W_LAST    = WD_SLOT + DATA_W;
    localparam int R_LAST    = RD_SLOT + DATA_W;
    localparam int NUM_SLOTS = W_LAST + 1;
    localparam int SLOT_W    = $clog2(NUM_SLOTS);

    typedef logic [SLOT_W-1:0] slot_t;

    localparam slot_t S_ST = slot_t'(ST_SLOT);
    localparam slot_t S_OP = slot_t'(OP_SLOT);
    localparam slot_t S_PA = slot_t'(PA_SLOT);
    localparam slot_t S_RA = slot_t'(RA_SLOT);
    localparam slot_t S_TA = slot_t'(TA_SLOT);
    localparam slot_t S_WD = slot_t'(WD_SLOT);
    localparam slot_t S_RD = slot_t'(RD_SLOT);
    localparam slot_t S_WL = slot_t'(W_LAST);
    localparam slot_t S_RL = slot_t'(R_LAST);

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;
endpackage

// File: rtl/mdio_half_timer.sv
module mdio_half_timer #(
    parameter int HALF_DIV = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic tick_o
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LIMIT = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = run_i && (cnt_q == LIMIT);
        if (!run_i || tick_o) cnt_d = '0;
        else                  cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LIMIT);

    // R2
    cnt_idle_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> (cnt_q == '0));
endmodule

// File: rtl/mdio_slot_decode.sv
module mdio_slot_decode
    import mdio_pkg::*;
(
    input  slot_t             idx_i,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] phy_i,
    input  logic [ADDR_W-1:0] regad_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              drv_o,
    output logic              val_o
);
    slot_t             off_pa, off_ra, off_wd;
    logic [ADDR_W-1:0] phy_sh, reg_sh;
    logic [DATA_W-1:0] wd_sh;

    always_comb begin
        off_pa = idx_i - S_PA;
        off_ra = idx_i - S_RA;
        off_wd = idx_i - S_WD;
        phy_sh = phy_i   << off_pa[AOFF_W-1:0];
        reg_sh = regad_i << off_ra[AOFF_W-1:0];
        wd_sh  = wdata_i << off_wd[DOFF_W-1:0];
        drv_o  = 1'b0;
        val_o  = 1'b0;
        if (idx_i < S_ST) begin
            drv_o = 1'b1;
            val_o = 1'b1;
        end else if (idx_i < S_OP) begin
            drv_o = 1'b1;
            val_o = (idx_i != S_ST);
        end else if (idx_i < S_PA) begin
            drv_o = 1'b1;
            val_o = (idx_i == S_OP) ? rd_i : !rd_i;
        end else if (idx_i < S_RA) begin
            drv_o = 1'b1;
            val_o = phy_sh[ADDR_W-1];
        end else if (idx_i < S_TA) begin
            drv_o = 1'b1;
            val_o = reg_sh[ADDR_W-1];
        end else if (rd_i) begin
            drv_o = 1'b0;
        end else if (idx_i < S_WD) begin
            drv_o = 1'b1;
            val_o = (idx_i == S_TA);
        end else if (idx_i < S_WL) begin
            drv_o = 1'b1;
            val_o = wd_sh[DATA_W-1];
        end
    end
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid_i,
    output logic              req_ready_o,
    input  logic              req_read_i,
    input  logic [ADDR_W-1:0] req_phy_i,
    input  logic [ADDR_W-1:0] req_reg_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    output logic              done_o,
    output logic [DATA_W-1:0] rdata_o,
    input  logic              tick_i,
    output logic              run_o,
    output logic              mdc_o,
    output logic              mdio_o_o,
    output logic              mdio_oe_o,
    input  logic              mdio_i
);
    typedef struct packed {
        seq_state_e        st;
        logic              rd;
        logic [ADDR_W-1:0] phy;
        logic [ADDR_W-1:0] regad;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        slot_t             idx;
        logic              hi;
        logic              mdc;
        logic              done;
    } seq_t;

    seq_t q, d;
    logic drv, val;
    logic last_slot, rd_sample;

    mdio_slot_decode u_dec (
        .idx_i   (q.idx),
        .rd_i    (q.rd),
        .phy_i   (q.phy),
        .regad_i (q.regad),
        .wdata_i (q.wdata),
        .drv_o   (drv),
        .val_o   (val)
    );

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        last_slot = (q.idx == (q.rd ? S_RL : S_WL));
        rd_sample = q.rd && (q.idx >= S_RD) && (q.idx < S_RL);
        case (q.st)
            SEQ_IDLE: begin
                if (req_valid_i) begin
                    d.st    = SEQ_RUN;
                    d.rd    = req_read_i;
                    d.phy   = req_phy_i;
                    d.regad = req_reg_i;
                    d.wdata = req_wdata_i;
                    d.idx   = '0;
                    d.hi    = 1'b0;
                    d.mdc   = 1'b0;
                end
            end
            SEQ_RUN: begin
                if (tick_i) begin
                    if (!q.hi) begin
                        d.hi  = 1'b1;
                        d.mdc = 1'b1;
                    end else begin
                        d.hi  = 1'b0;
                        d.mdc = 1'b0;
                        if (rd_sample) d.rdata = {q.rdata[DATA_W-2:0], mdio_i};
                        if (last_slot) begin
                            d.st   = SEQ_IDLE;
                            d.done = 1'b1;
                            d.idx  = '0;
                        end else begin
                            d.idx = q.idx + 1'b1;
                        end
                    end
                end
            end
            default: d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign run_o       = (q.st == SEQ_RUN);
    assign req_ready_o = (q.st == SEQ_IDLE);
    assign done_o      = q.done;
    assign rdata_o     = q.rdata;
    assign mdc_o       = q.mdc;
    assign mdio_oe_o   = run_o && drv;
    assign mdio_o_o    = run_o && drv && val;

    // R1
    idle_mdc_low_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready_o |-> (!mdc_o && !mdio_oe_o));

    // R2
    line_stable_high_chk: assert property (@(posedge clk) disable iff (rst)
        (mdc_o && $past(mdc_o)) |-> ($stable(mdio_oe_o) && $stable(mdio_o_o)));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R8
    take_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i && req_ready_o) |=> !req_ready_o);

    // R8
    done_ready_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> req_ready_o);

    // R8
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (req_ready_o && !req_valid_i) |=> $stable(rdata_o));
endmodule

// File: rtl/mdio_master.sv
module mdio_master #(
    parameter int HALF_DIV = 10
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic        req_read,
    input  logic [4:0]  req_phy,
    input  logic [4:0]  req_reg,
    input  logic [15:0] req_wdata,
    output logic        rsp_done,
    output logic [15:0] rsp_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic tick, run;

    mdio_half_timer #(.HALF_DIV(HALF_DIV)) u_tmr (
        .clk    (clk),
        .rst    (rst),
        .run_i  (run),
        .tick_o (tick)
    );

    mdio_frame_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .req_valid_i (req_valid),
        .req_ready_o (req_ready),
        .req_read_i  (req_read),
        .req_phy_i   (req_phy),
        .req_reg_i   (req_reg),
        .req_wdata_i (req_wdata),
        .done_o      (rsp_done),
        .rdata_o     (rsp_rdata),
        .tick_i      (tick),
        .run_o       (run),
        .mdc_o       (mdc),
        .mdio_o_o    (mdio_o),
        .mdio_oe_o   (mdio_oe),
        .mdio_i      (mdio_i)
    );
endmodule

// File: tb/sim_mdio_master.sv
module sim_mdio_master;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int HALF = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_read = 1'b0;
    logic [4:0]  req_phy = '0;
    logic [4:0]  req_reg = '0;
    logic [15:0] req_wdata = '0;
    logic        rsp_done;
    logic [15:0] rsp_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        phy_in = 1'b1;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    mdio_master #(.HALF_DIV(HALF)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_read(req_read), .req_phy(req_phy), .req_reg(req_reg),
        .req_wdata(req_wdata), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(phy_in)
    );

    // frame monitor state
    bit          in_frame = 0;
    int          nslot, hi_run, lo_run, bad_run;
    bit          s_oe[80];
    bit          s_do[80];
    bit          e_oe[80];
    bit          e_do[80];
    int          e_n;
    logic        mdc_prev = 1'b0, oe_prev = 1'b0, do_prev = 1'b0;
    bit          cur_rd;
    logic [15:0] phy_data;
    logic [15:0] got_rdata;
    logic        got_ready;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (in_frame) begin
            if (mdc) hi_run++; else lo_run++;
            if (mdc && !mdc_prev) begin
                if (lo_run != HALF) bad_run++;
                lo_run = 0;
                if (nslot < 80) begin
                    s_oe[nslot] = mdio_oe;
                    s_do[nslot] = mdio_o;
                end
                if (cur_rd && nslot >= 55 && nslot <= 70) phy_in = phy_data[70 - nslot];
                else if (cur_rd && nslot == 54) phy_in = ~phy_data[15];
                else if (cur_rd && nslot == 71) phy_in = ~phy_data[0];
                else phy_in = 1'b1;
                nslot++;
            end
            if (!mdc && mdc_prev) begin
                if (hi_run != HALF) bad_run++;
                hi_run = 0;
            end
            if (mdc && mdc_prev && (mdio_oe != oe_prev || mdio_o != do_prev)) bad_run++;
        end
        mdc_prev = mdc;
        oe_prev  = mdio_oe;
        do_prev  = mdio_o;
    end

    task automatic put(input bit oe, input bit v);
        e_oe[e_n] = oe;
        e_do[e_n] = v;
        e_n++;
    endtask

    task automatic start_mon(input bit rd, input logic [4:0] pa,
                             input logic [4:0] ra, input logic [15:0] wd);
        e_n = 0;
        repeat (40) put(1, 1);
        put(1, 0); put(1, 1);
        put(1, rd); put(1, !rd);
        for (int i = 4; i >= 0; i--) put(1, pa[i]);
        for (int i = 4; i >= 0; i--) put(1, ra[i]);
        if (rd) begin
            repeat (18) put(0, 0);
        end else begin
            put(1, 1); put(1, 0);
            for (int i = 15; i >= 0; i--) put(1, wd[i]);
            put(0, 0);
        end
        cur_rd = rd; nslot = 0; hi_run = 0; lo_run = 0; bad_run = 0;
        in_frame = 1;
    endtask

    task automatic launch(input bit rd, input logic [4:0] pa,
                          input logic [4:0] ra, input logic [15:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_read = rd; req_phy = pa; req_reg = ra; req_wdata = wd;
        while (!req_ready) @(negedge clk);
        @(posedge clk); #1;
        start_mon(rd, pa, ra, wd);
        req_valid = 1'b0;
    endtask

    task automatic wait_done;
        @(negedge clk);
        while (!rsp_done) @(negedge clk);
        got_rdata = rsp_rdata;
        got_ready = req_ready;
        #1 in_frame = 0;
    endtask

    function automatic int seg_bad(input int lo, input int hi);
        int b = 0;
        for (int k = lo; k < hi && k < 80; k++)
            if (s_oe[k] != e_oe[k] || (e_oe[k] && s_do[k] != e_do[k])) b++;
        return b;
    endfunction

    task automatic verify;
        string tt;
        tt = cur_rd ? "R7" : "R6";
        chk(nslot == e_n, tt, "pulse count", nslot, e_n);
        chk(seg_bad(0, 40) == 0, "R3", "preamble bad slots", seg_bad(0, 40), 0);
        chk(seg_bad(40, 44) == 0, "R4", "start/opcode bad slots", seg_bad(40, 44), 0);
        chk(seg_bad(44, 54) == 0, "R5", "address bad slots", seg_bad(44, 54), 0);
        chk(seg_bad(54, e_n) == 0, tt, "tail bad slots", seg_bad(54, e_n), 0);
        chk(bad_run == 0, "R2", "half-period/stability faults", bad_run, 0);
        chk(got_ready == 1'b1, "R8", "ready with done", int'(got_ready), 1);
        if (cur_rd) chk(got_rdata == phy_data, "R7", "read data", int'(got_rdata), int'(phy_data));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] da, db;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!mdc && !mdio_oe, "R1", "mdc/oe in reset", int'({mdc, mdio_oe}), 0);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        chk(req_ready && !rsp_done, "R1", "ready after reset", int'({req_ready, rsp_done}), 2);

        // write sweep over every PHY address
        for (int p = 0; p < 32; p++) begin
            launch(1'b0, 5'(p), 5'(31 - p), 16'(p * 2081) ^ 16'hA5C3);
            wait_done();
            verify();
        end

        // read sweep over walking data patterns
        for (int i = 0; i < 16; i++) begin
            phy_data = (16'h1 << i) ^ ((i % 2) ? 16'hFFFF : 16'h0000);
            launch(1'b1, 5'(i * 7), 5'(i * 3 + 1), 16'hFFFF);
            wait_done();
            verify();
            repeat (4) @(negedge clk);
            chk(rsp_rdata == phy_data, "R8", "read data held", int'(rsp_rdata), int'(phy_data));
            chk(!mdc && !mdio_oe, "R1", "idle after frame", int'({mdc, mdio_oe}), 0);
        end

        // R8 ignored fields during a frame, R9 back-to-back acceptance
        da = 16'h3C96; db = 16'hE10F;
        phy_data = da;
        launch(1'b1, 5'h15, 5'h0A, 16'h0000);
        req_valid = 1'b1; req_read = 1'b1; req_phy = 5'h0B; req_reg = 5'h1C; req_wdata = 16'h5555;
        wait_done();
        verify();
        chk(req_valid && got_ready, "R9", "done while request pending", int'(got_ready), 1);
        @(posedge clk); #1;
        phy_data = db;
        start_mon(1'b1, 5'h0B, 5'h1C, 16'h5555);
        @(negedge clk);
        chk(!req_ready, "R9", "second request taken next edge", int'(req_ready), 0);
        req_valid = 1'b0;
        wait_done();
        verify();

        // R1 reset in the middle of a frame
        launch(1'b0, 5'h1F, 5'h00, 16'hFFFF);
        repeat (100) @(negedge clk);
        in_frame = 0;
        rst = 1'b1;
        @(negedge clk);
        chk(!mdc && !mdio_oe, "R1", "mid-frame reset lines", int'({mdc, mdio_oe}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "ready after mid-frame reset", int'(req_ready), 1);
        launch(1'b0, 5'h01, 5'h02, 16'h8001);
        wait_done();
        verify();

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule